// File: doc/BRIEF.md
# Memory Ordering Issue Gate

The block sits between an in-order operation stream and a memory port. Each operation carries a 3-bit kind code and a tag. The block passes an operation to memory only when the ordering rules for its kind allow it. Loads and stores flow freely. Fences and atomics drain all earlier work and then hold back everything behind them. Acquires go out at once but hold back everything behind them. Releases drain all earlier work, but they do not hold back what follows.

A single saturating counter tracks every operation that has been issued and not yet completed. The memory system returns one completion pulse per issued operation, and the pulse carries the tag of that operation. A one-entry blocking record keeps the tag of the most recent fence, atomic or acquire. Issue stays closed until a completion with that tag arrives. The issue path is a plain valid/ready pass-through. Upstream keeps presenting the same operation until it is accepted, so program order is preserved.

Top module: `mem_order_gate`

## Requirements
- R1: Loads (code 000) and stores (code 001) issue in the cycle they are presented, even with earlier operations still outstanding. The only exceptions are a pending blocking operation and a saturated counter.
- R2: Each issued operation raises the outstanding count by one and each counted completion lowers it by one. With 15 outstanding, no operation issues until a completion arrives.
- R3: A fence (code 010) issues only when zero operations are outstanding. After it issues, every later operation stalls until a completion carrying the fence's tag arrives.
- R4: An atomic (code 011) follows the same two-sided rule as a fence: it drains before issue and blocks after issue until its own completion.
- R5: An acquire (code 100) issues without waiting for earlier operations. Every later operation stalls until the acquire's own completion arrives.
- R6: A release (code 101) issues only when zero operations are outstanding. The operation right after it may issue in the next cycle without waiting for the release to complete.
- R7: An issue and a completion in the same cycle leave the outstanding count unchanged.
- R8: A completion that arrives with zero outstanding is ignored; the count does not wrap below zero.
- R9: A completion whose tag differs from the pending blocking operation's tag lowers the count but does not lift the block.
- R10: `mem_valid` is high exactly when an operation is presented and its ordering rule allows it, and the kind and tag pass through unchanged. When `mem_ready` is low, the operation is held and `stall` is high.
- R11: After reset the count is zero and no block is pending, so a fence presented first issues at once. With no operation presented, `mem_valid` and `stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Upstream operation present |
| op_kind | input | 3 | Operation kind code |
| op_tag | input | TAG_W | Operation tag |
| op_ready | output | 1 | Operation accepted this cycle |
| stall | output | 1 | Operation present but not accepted |
| mem_valid | output | 1 | Operation offered to memory |
| mem_kind | output | 3 | Kind code toward memory |
| mem_tag | output | TAG_W | Tag toward memory |
| mem_ready | input | 1 | Memory accepts the offered operation |
| cpl_valid | input | 1 | Completion pulse from memory |
| cpl_tag | input | TAG_W | Tag of the completed operation |

## Verification
The checker watches several rules on every cycle. Nothing is offered to memory while a block is pending or the counter is saturated. No draining kind is offered with work outstanding. An issue without a completion raises the count by exactly one, and simultaneous or empty-count completions leave the count where the rules say. Only the bench scenarios show the ordering sequences end to end. These include a release held across a run of completions and then followed at once by a store, and a fence block that survives a foreign-tag completion. They also cover saturation at fifteen and the exact sequence of kinds and tags that reaches memory.

// File: rtl/mog_pkg.sv
package mog_pkg;

    localparam int KIND_W    = 3;
    localparam int NUM_CODES = 1 << KIND_W;

    typedef enum logic [KIND_W-1:0] {
        K_LOAD    = 3'b000,
        K_STORE   = 3'b001,
        K_FENCE   = 3'b010,
        K_ATOMIC  = 3'b011,
        K_ACQUIRE = 3'b100,
        K_RELEASE = 3'b101
    } op_kind_e;

    // Ordering policy attached to one kind code
    typedef struct packed {
        logic drain_first;  // wait for zero outstanding before issue
        logic block_after;  // hold later issue until own completion
    } policy_t;

    function automatic policy_t policy_of(input logic [KIND_W-1:0] code);
        policy_t p;
        unique case (code)
            K_LOAD, K_STORE: p = '{drain_first: 1'b0, block_after: 1'b0};
            K_ACQUIRE:       p = '{drain_first: 1'b0, block_after: 1'b1};
            K_RELEASE:       p = '{drain_first: 1'b1, block_after: 1'b0};
            default:         p = '{drain_first: 1'b1, block_after: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mog_counter.sv
module mog_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_q,
    output logic             full,
    output logic             empty
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic dec_eff;

    // a completion with nothing outstanding is dropped
    assign dec_eff = dec && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc && !dec_eff) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (!inc && dec_eff) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign full  = (cnt_q == CNT_MAX);
    assign empty = (cnt_q == '0);
endmodule

// File: rtl/mog_block_track.sv
module mog_block_track #(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag,
    output logic             blk_q
);
    logic [TAG_W-1:0] held_tag_q;
    logic             hit;

    assign hit = blk_q && cpl_valid && (cpl_tag == held_tag_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q      <= 1'b0;
            held_tag_q <= '0;
        end else if (set) begin
            blk_q      <= 1'b1;
            held_tag_q <= set_tag;
        end else if (hit) begin
            blk_q      <= 1'b0;
        end
    end
endmodule

// File: rtl/mog_gate.sv
module mog_gate (
    input  logic                         blk,
    input  logic                         full,
    input  logic                         empty,
    input  logic [mog_pkg::KIND_W-1:0]   kind,
    output logic                         open,
    output logic                         sets_block
);
    import mog_pkg::*;

    logic                 base_ok;
    logic [NUM_CODES-1:0] allow;
    logic [NUM_CODES-1:0] blocks;

    assign base_ok = !blk && !full;

    for (genvar c = 0; c < NUM_CODES; c++) begin : g_pol
        localparam policy_t POL = policy_of(KIND_W'(c));
        assign allow[c]  = POL.drain_first ? (base_ok && empty) : base_ok;
        assign blocks[c] = POL.block_after;
    end

    assign open       = allow[kind];
    assign sets_block = blocks[kind];
endmodule

// File: rtl/mem_order_gate.sv
module mem_order_gate #(
    parameter int CNT_W = 4,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [2:0]       op_kind,
    input  logic [TAG_W-1:0] op_tag,
    output logic             op_ready,
    output logic             stall,
    output logic             mem_valid,
    output logic [2:0]       mem_kind,
    output logic [TAG_W-1:0] mem_tag,
    input  logic             mem_ready,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag
);
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_full;
    logic             cnt_empty;
    logic             blk_q;
    logic             gate_open;
    logic             kind_blocks;
    logic             issue;

    mog_gate u_gate (
        .blk        (blk_q),
        .full       (cnt_full),
        .empty      (cnt_empty),
        .kind       (op_kind),
        .open       (gate_open),
        .sets_block (kind_blocks)
    );

    assign mem_valid = op_valid && gate_open;
    assign mem_kind  = op_kind;
    assign mem_tag   = op_tag;
    assign op_ready  = gate_open && mem_ready;
    assign issue     = mem_valid && mem_ready;
    assign stall     = op_valid && !op_ready;

    mog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (issue),
        .dec   (cpl_valid),
        .cnt_q (cnt_q),
        .full  (cnt_full),
        .empty (cnt_empty)
    );

    mog_block_track #(.TAG_W(TAG_W)) u_blk (
        .clk       (clk),
        .rst       (rst),
        .set       (issue && kind_blocks),
        .set_tag   (op_tag),
        .cpl_valid (cpl_valid),
        .cpl_tag   (cpl_tag),
        .blk_q     (blk_q)
    );
endmodule

// File: rtl/mog_checker.sv
module mog_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic             stall,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic [2:0]       mem_kind,
    input logic             cpl_valid,
    input logic [CNT_W-1:0] cnt,
    input logic             blk
);
    import mog_pkg::*;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic issue;
    assign issue = mem_valid && mem_ready;

    // R2
    sat_no_offer_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX) |-> !mem_valid);

    // R3
    drain_kind_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && policy_of(mem_kind).drain_first) |-> (cnt == '0));

    // R5
    block_holds_issue_chk: assert property (@(posedge clk) disable iff (rst)
        blk |-> !mem_valid);

    // R2
    issue_raises_count_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && !cpl_valid) |=> (cnt == $past(cnt) + 1'b1));

    // R7
    balanced_count_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && cpl_valid && cnt != '0) |=> $stable(cnt));

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && cpl_valid && !issue) |=> (cnt == '0));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> (!mem_valid && !stall));
endmodule

bind mem_order_gate mog_checker #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .stall     (stall),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_kind  (mem_kind),
    .cpl_valid (cpl_valid),
    .cnt       (cnt_q),
    .blk       (blk_q)
);

// File: tb/mem_order_gate_tb_top.sv
module mem_order_gate_tb_top;
    localparam int TAG_W = 6;
    localparam logic [2:0] LD = 3'b000, ST = 3'b001, FN = 3'b010,
                           AT = 3'b011, AQ = 3'b100, RL = 3'b101;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             op_valid = 1'b0;
    logic [2:0]       op_kind = '0;
    logic [TAG_W-1:0] op_tag = '0;
    logic             op_ready, stall, mem_valid;
    logic [2:0]       mem_kind;
    logic [TAG_W-1:0] mem_tag;
    logic             mem_ready = 1'b1;
    logic             cpl_valid = 1'b0;
    logic [TAG_W-1:0] cpl_tag = '0;

    int checks = 0;
    int failures = 0;
    logic [2+TAG_W:0] exp_q[$];

    always #4 clk = ~clk;

    mem_order_gate #(.CNT_W(4), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .op_kind(op_kind), .op_tag(op_tag),
        .op_ready(op_ready), .stall(stall),
        .mem_valid(mem_valid), .mem_kind(mem_kind), .mem_tag(mem_tag),
        .mem_ready(mem_ready),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: every accepted operation must match the head of the scoreboard
    always @(negedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected issue", int'({mem_kind, mem_tag}), -1);
            end else begin
                logic [2+TAG_W:0] e;
                e = exp_q.pop_front();
                check({mem_kind, mem_tag} == e, "R10 issue order", int'({mem_kind, mem_tag}), int'(e));
            end
        end
    end

    task automatic put(input logic [2:0] k, input int t);
        op_valid = 1'b1;
        op_kind  = k;
        op_tag   = TAG_W'(t);
        exp_q.push_back({k, TAG_W'(t)});
    endtask

    task automatic cpl(input int t);
        cpl_valid = 1'b1;
        cpl_tag   = TAG_W'(t);
    endtask

    // one cycle: check stall at negedge, advance, drop pulse and accepted op
    task automatic cyc(input bit exp_stall, input string req);
        bit s;
        @(negedge clk);
        s = stall;
        check(s == exp_stall, req, int'(s), int'(exp_stall));
        @(posedge clk);
        #1;
        cpl_valid = 1'b0;
        if (!s) op_valid = 1'b0;
    endtask

    task automatic done(input int t);
        cpl(t);
        cyc(1'b0, "R2 completion");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!mem_valid && !stall, "R11 idle after reset", int'({mem_valid, stall}), 0);
        @(posedge clk); #1;
        put(FN, 1);  cyc(1'b0, "R11 fence at reset");
        done(1);

        // R1 free loads/stores, R6 release drain then pass-through
        put(LD, 2);  cyc(1'b0, "R1");
        put(ST, 3);  cyc(1'b0, "R1");
        put(LD, 4);  cyc(1'b0, "R1");
        put(RL, 5);  cyc(1'b1, "R6 release waits");
        cpl(2);      cyc(1'b1, "R6 release waits");
        cpl(3);      cyc(1'b1, "R6 release waits");
        cpl(4);      cyc(1'b1, "R6 release waits");
        cyc(1'b0, "R6 release issues");
        put(ST, 6);  cyc(1'b0, "R6 store after release");
        done(5); done(6);

        // R3 fence, R9 foreign tag, R8 empty completion
        put(ST, 7);  cyc(1'b0, "R1");
        put(FN, 8);  cyc(1'b1, "R3 fence waits");
        cpl(7);      cyc(1'b1, "R3 fence waits");
        cyc(1'b0, "R3 fence issues");
        put(LD, 9);  cyc(1'b1, "R3 load after fence");
        cpl(50);     cyc(1'b1, "R9 foreign tag");
        cyc(1'b1, "R9 block kept");
        cpl(8);      cyc(1'b1, "R3 load after fence");
        cyc(1'b0, "R8 load issues");
        put(RL, 10); cyc(1'b1, "R8 no wrap");
        cpl(9);      cyc(1'b1, "R8 no wrap");
        cyc(1'b0, "R8 release issues");
        done(10);

        // R4 atomic
        put(ST, 11); cyc(1'b0, "R1");
        put(AT, 12); cyc(1'b1, "R4 atomic waits");
        cpl(11);     cyc(1'b1, "R4 atomic waits");
        cyc(1'b0, "R4 atomic issues");
        put(ST, 13); cyc(1'b1, "R4 store after atomic");
        cpl(12);     cyc(1'b1, "R4 store after atomic");
        cyc(1'b0, "R4 store issues");
        done(13);

        // R5 acquire
        put(ST, 14); cyc(1'b0, "R1");
        put(AQ, 15); cyc(1'b0, "R5 acquire no wait");
        put(LD, 16); cyc(1'b1, "R5 load after acquire");
        cpl(15);     cyc(1'b1, "R5 load after acquire");
        cyc(1'b0, "R5 load issues");
        done(14); done(16);

        // R2 saturation at 15
        for (int i = 0; i < 15; i++) begin
            put(ST, 20 + i); cyc(1'b0, "R2 fill");
        end
        put(ST, 35); cyc(1'b1, "R2 saturated");
        cpl(20);     cyc(1'b1, "R2 saturated");
        cyc(1'b0, "R2 after completion");
        for (int i = 21; i <= 35; i++) done(i);

        // R7 simultaneous issue and completion
        put(ST, 40); cyc(1'b0, "R1");
        put(ST, 41); cpl(40); cyc(1'b0, "R7 issue with completion");
        put(RL, 42); cyc(1'b1, "R7 one outstanding");
        cpl(41);     cyc(1'b1, "R7 one outstanding");
        cyc(1'b0, "R7 release issues");
        done(42);

        // R10 memory back-pressure
        mem_ready = 1'b0;
        put(LD, 43);
        @(negedge clk);
        check(mem_valid && stall && mem_tag == TAG_W'(43), "R10 held",
              int'({mem_valid, stall}), 3);
        @(posedge clk); #1;
        mem_ready = 1'b1;
        cyc(1'b0, "R10 accepted");
        done(43);

        check(exp_q.size() == 0, "R10 all issued", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule